// File: doc/BRIEF.md
# Serial Clock and Character Framing Generator

This block drives the serial side of a synchronous serial master for one transaction at a time. Each chip select has its own 32-bit mode word. When a transaction starts, the block latches the word of the chosen select and asserts that select's line. It waits a programmed setup interval and then shifts characters out on the data output while it samples the data input. Between characters it inserts a programmed idle gap. After the last character it waits a programmed hold interval and releases the select line.

The mode word sets the following:
- the clock rest level and the clock phase;
- the bit order and the character length;
- a prescaler with an optional extra divide-by-16;
- the three framing intervals (setup, gap, hold).

Characters come from a simple per-character request. The block pulses a request once per character and takes the character data and an end-of-transaction flag on the closing edge of that cycle. It returns each received character right-aligned, with a one-cycle valid pulse. Byte counting and data queues belong to the surrounding controller.

The half period H of the serial clock is 2×(PM+1) system clocks, multiplied by 16 when the divide-by-16 bit is set. All framing intervals are whole serial periods, that is, even multiples of H.

Top module: `spi_frame_gen`

## Requirements
- R1: While reset is held, every select line rests at its inactive level (high when bit 20 of its word is 1, low when it is 0), the serial clock is low, and no request or valid pulse is given.
- R2: The serial clock period is 4×(PM+1) system clocks, with PM in word bits 27:24. The period is 16 times longer when bit 28 is set. It is measured from the first to the third clock edge of a transaction.
- R3: The serial clock rests at the level of word bit 31 whenever no character is being shifted, including at the moment the select line is asserted.
- R4: Word bit 30 selects the clock phase. With 0, the first clock edge of a bit comes H after the bit starts, and the input is sampled on that edge. With 1, the first edge comes when the bit starts, and the input is sampled on the second edge. The data output changes only on non-sampling edges.
- R5: Word bits 19:16 hold the character length minus one. Codes 0, 1 and 2 are treated as a 4-bit character, so lengths run from 4 to 16. Word bit 29 = 1 sends the most significant bit first; 0 sends the least significant bit first. Received data comes back in the same order.
- R6: From select assertion to the first clock edge, 2×S×H + 1 + (bit 30 = 0 ? H : 0) system clocks pass, with S in word bits 15:12.
- R7: From the last clock edge of the last character to select release, 2×A×H system clocks pass, plus H when bit 30 = 1, with A in word bits 11:8.
- R8: From the last clock edge of one character to the first clock edge of the next, 2×G×H + H + 1 system clocks pass, with G in word bits 7:3.
- R9: When word bit 20 is 1 the selected line is driven low while the select is active; when it is 0 the line is driven high. Only the selected line ever leaves its inactive level.
- R10: Each character gives exactly one one-cycle request pulse. The data and last flag are taken at the end of that cycle. Each character also gives exactly one one-cycle valid pulse carrying the received bits, right-aligned.
- R11: A start pulse or a select change that arrives while a transaction is running has no effect on that transaction and starts nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_mode_i | input | NUM_CS*32 | Mode words, select k in bits 32k+31:32k |
| cs_sel_i | input | SEL_W | Select to use for the next transaction |
| start_i | input | 1 | Starts a transaction when idle |
| chr_data_i | input | 16 | Character to send, taken when chr_req_o is high |
| chr_last_i | input | 1 | Marks the character being taken as the last one |
| chr_req_o | output | 1 | One-cycle request for the next character |
| rx_data_o | output | 16 | Received character, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Select lines, levels per bit 20 of each word |

## Verification
The hardest situation to reach is a start pulse together with a changed select value that lands mid-transaction, while the block is taking a character. The stimulus raises both in the same cycle as the second character request. It then checks that the other select line never moves, and that the running transaction keeps its exact request count and framing times.

The divide-by-16 path, the clamped short length code and the zero-length gap and hold cases are each reached by a dedicated mode word. Edge-to-edge intervals are measured at the pins to confirm them.

// File: rtl/spi_fg_pkg.sv
package spi_fg_pkg;

    localparam int WORD_W   = 32;
    localparam int CHAR_MAX = 16;
    localparam int LEN_W    = 5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOAD  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_GAP   = 3'd4,
        ST_HOLD  = 3'd5
    } fg_state_e;

    // Decoded per-select timing fields
    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       msb_first;
        logic       div16;
        logic [3:0] pm;
        logic [3:0] len_m1;
        logic [3:0] setup;
        logic [3:0] hold;
        logic [4:0] gap;
    } fg_mode_t;

    function automatic fg_mode_t decode_mode(input logic [WORD_W-1:0] w);
        fg_mode_t m;
        m.cpol      = w[31];
        m.cpha      = w[30];
        m.msb_first = w[29];
        m.div16     = w[28];
        m.pm        = w[27:24];
        m.len_m1    = w[19:16];
        m.setup     = w[15:12];
        m.hold      = w[11:8];
        m.gap       = w[7:3];
        return m;
    endfunction

    // Short length codes are raised to a 4-bit character
    function automatic logic [LEN_W-1:0] char_len(input logic [3:0] code);
        if (code < 4'd3) begin
            return LEN_W'(4);
        end
        return {1'b0, code} + LEN_W'(1);
    endfunction

endpackage

// File: rtl/fg_divider.sv
module fg_divider #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] half_len,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == half_len - CNT_W'(1));
        cnt_d = cnt_q + CNT_W'(1);
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/fg_shifter.sv
module fg_shifter #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic          msb_first,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  data_in,
    input  logic          miso,
    output logic          mosi,
    output logic [W-1:0]  rx_word
);

    typedef struct packed {
        logic [W-1:0] tx;
        logic [W-1:0] rx;
    } sh_regs_t;

    sh_regs_t      s_d, s_q;
    logic [LW-1:0] pad;
    logic [W:0]    full;
    logic [W-1:0]  mask;

    always_comb begin
        pad  = LW'(W) - len;
        full = ((W+1)'(1) << len) - (W+1)'(1);
        mask = full[W-1:0];
        s_d  = s_q;
        if (load) begin
            s_d.tx = msb_first ? (data_in << pad) : data_in;
            s_d.rx = '0;
        end else begin
            if (shift_en) begin
                s_d.tx = msb_first ? (s_q.tx << 1) : (s_q.tx >> 1);
            end
            if (sample_en) begin
                s_d.rx = msb_first ? {s_q.rx[W-2:0], miso} : {miso, s_q.rx[W-1:1]};
            end
        end
        mosi    = msb_first ? s_q.tx[W-1] : s_q.tx[0];
        rx_word = msb_first ? (s_q.rx & mask) : (s_q.rx >> pad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/spi_frame_gen.sv
module spi_frame_gen
    import spi_fg_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 10,
    parameter int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CS*WORD_W-1:0] cs_mode_i,
    input  logic [SEL_W-1:0]         cs_sel_i,
    input  logic                     start_i,
    input  logic [CHAR_MAX-1:0]      chr_data_i,
    input  logic                     chr_last_i,
    output logic                     chr_req_o,
    output logic [CHAR_MAX-1:0]      rx_data_o,
    output logic                     rx_valid_o,
    output logic                     sck_o,
    output logic                     mosi_o,
    input  logic                     miso_i,
    output logic [NUM_CS-1:0]        cs_o
);

    localparam int DLY_W = 6;

    typedef struct packed {
        fg_state_e           st;
        logic [SEL_W-1:0]    sel;
        fg_mode_t            mode;
        logic                half;
        logic [LEN_W-1:0]    bits;
        logic [DLY_W-1:0]    dly;
        logic                last;
        logic                act;
        logic                sck;
        logic                req;
        logic                rxv;
        logic [CHAR_MAX-1:0] rxd;
    } fg_regs_t;

    fg_regs_t            r_d, r_q;
    logic [WORD_W-1:0]   words [NUM_CS];
    logic [NUM_CS-1:0]   pol_low;
    fg_mode_t            mode_live;
    logic [CNT_W-1:0]    half_len;
    logic [CNT_W-1:0]    div_cnt;
    logic [LEN_W-1:0]    len_eff;
    logic                tick;
    logic                restart;
    logic                shift_en;
    logic                sample_en;
    logic                sh_mosi;
    logic [CHAR_MAX-1:0] rx_word;

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_sel
            assign words[g]   = cs_mode_i[g*WORD_W +: WORD_W];
            assign pol_low[g] = words[g][20];
            assign cs_o[g]    = (r_q.act && (r_q.sel == SEL_W'(g))) ? ~pol_low[g] : pol_low[g];
        end
    endgenerate

    assign mode_live = decode_mode(words[cs_sel_i]);
    assign half_len  = (CNT_W'(r_q.mode.pm) + CNT_W'(1)) << (r_q.mode.div16 ? 5 : 1);
    assign len_eff   = char_len(r_q.mode.len_m1);
    assign restart   = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);

    fg_divider #(.CNT_W(CNT_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .half_len (half_len),
        .tick     (tick),
        .cnt_o    (div_cnt)
    );

    fg_shifter #(.W(CHAR_MAX), .LW(LEN_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (r_q.st == ST_LOAD),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .msb_first (r_q.mode.msb_first),
        .len       (len_eff),
        .data_in   (chr_data_i),
        .miso      (miso_i),
        .mosi      (sh_mosi),
        .rx_word   (rx_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.req   = 1'b0;
        r_d.rxv   = 1'b0;
        shift_en  = 1'b0;
        sample_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck = mode_live.cpol;
                if (start_i) begin
                    r_d.sel  = cs_sel_i;
                    r_d.mode = mode_live;
                    r_d.act  = 1'b1;
                    if (mode_live.setup != 4'd0) begin
                        r_d.st  = ST_SETUP;
                        r_d.dly = DLY_W'({mode_live.setup, 1'b0});
                    end else begin
                        r_d.st  = ST_LOAD;
                        r_d.req = 1'b1;
                    end
                end
            end
            ST_SETUP, ST_GAP: begin
                if (tick) begin
                    r_d.dly = r_q.dly - DLY_W'(1);
                    if (r_q.dly == DLY_W'(1)) begin
                        r_d.st  = ST_LOAD;
                        r_d.req = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                r_d.st   = ST_SHIFT;
                r_d.half = 1'b0;
                r_d.bits = len_eff;
                r_d.last = chr_last_i;
                r_d.sck  = r_q.mode.cpol ^ r_q.mode.cpha;
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.half) begin
                        r_d.half  = 1'b1;
                        sample_en = 1'b1;
                        r_d.sck   = r_q.mode.cpol ^ ~r_q.mode.cpha;
                    end else if (r_q.bits == LEN_W'(1)) begin
                        r_d.rxv = 1'b1;
                        r_d.rxd = rx_word;
                        r_d.sck = r_q.mode.cpol;
                        if (r_q.last) begin
                            if (r_q.mode.hold != 4'd0) begin
                                r_d.st  = ST_HOLD;
                                r_d.dly = DLY_W'({r_q.mode.hold, 1'b0});
                            end else begin
                                r_d.st  = ST_IDLE;
                                r_d.act = 1'b0;
                            end
                        end else if (r_q.mode.gap != 5'd0) begin
                            r_d.st  = ST_GAP;
                            r_d.dly = DLY_W'({r_q.mode.gap, 1'b0});
                        end else begin
                            r_d.st  = ST_LOAD;
                            r_d.req = 1'b1;
                        end
                    end else begin
                        r_d.bits = r_q.bits - LEN_W'(1);
                        r_d.half = 1'b0;
                        shift_en = 1'b1;
                        r_d.sck  = r_q.mode.cpol ^ r_q.mode.cpha;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    r_d.dly = r_q.dly - DLY_W'(1);
                    if (r_q.dly == DLY_W'(1)) begin
                        r_d.st  = ST_IDLE;
                        r_d.act = 1'b0;
                    end
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.act = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign chr_req_o  = r_q.req;
    assign rx_data_o  = r_q.rxd;
    assign rx_valid_o = r_q.rxv;
    assign sck_o      = r_q.sck;
    assign mosi_o     = (r_q.st == ST_SHIFT) ? sh_mosi : 1'b0;

endmodule

// File: rtl/spi_frame_gen_chk.sv
module spi_frame_gen_chk
    import spi_fg_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_o,
    input logic [NUM_CS-1:0] pol_low,
    input logic              sck_o,
    input logic              chr_req_o,
    input logic              rx_valid_o,
    input fg_state_e         st_q,
    input logic [SEL_W-1:0]  sel_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  half_len
);

    logic [NUM_CS-1:0] active_lines;
    assign active_lines = cs_o ^ pol_low;

    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_lines));

    assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (cnt_q < half_len));

    assert_edges_in_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck_o) && st_q != ST_IDLE && $past(st_q) != ST_IDLE)
            |-> (st_q == ST_SHIFT || $past(st_q) == ST_SHIFT));

    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chr_req_o |=> !chr_req_o);

    assert_rxv_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(sel_q));

endmodule

bind spi_frame_gen spi_frame_gen_chk #(
    .NUM_CS (NUM_CS),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_o       (cs_o),
    .pol_low    (pol_low),
    .sck_o      (sck_o),
    .chr_req_o  (chr_req_o),
    .rx_valid_o (rx_valid_o),
    .st_q       (r_q.st),
    .sel_q      (r_q.sel),
    .cnt_q      (div_cnt),
    .half_len   (half_len)
);

// File: tb/test_spi_frame_gen.sv
`timescale 1ns/1ps
module test_spi_frame_gen;

    localparam int NUM_CS = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NUM_CS*32-1:0] cs_mode;
    logic [1:0]           cs_sel;
    logic                 start;
    logic [15:0]          chr_data;
    logic                 chr_last;
    logic                 chr_req;
    logic [15:0]          rx_data;
    logic                 rx_valid;
    logic                 sck;
    logic                 mosi;
    logic                 miso;
    logic [NUM_CS-1:0]    cs;

    always #2.5 clk = ~clk;
    assign miso = ~mosi;

    spi_frame_gen #(.NUM_CS(NUM_CS)) i_spi_frame_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_mode_i  (cs_mode),
        .cs_sel_i   (cs_sel),
        .start_i    (start),
        .chr_data_i (chr_data),
        .chr_last_i (chr_last),
        .chr_req_o  (chr_req),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .sck_o      (sck),
        .mosi_o     (mosi),
        .miso_i     (miso),
        .cs_o       (cs)
    );

    int total = 0;
    int bad   = 0;

    int q_setup[$];
    int q_per[$];
    int q_gap[$];
    int q_hold[$];
    int q_rx[$];
    int q_ser[$];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic pop_chk(ref int q[$], input string rq, input int act);
        if (q.size() == 0) begin
            chk(1'b0, rq, act, -1);
        end else begin
            chk(act == q[0], rq, act, q[0]);
            void'(q.pop_front());
        end
    endtask

    function automatic int rev_bits(input int d, input int l);
        int r = 0;
        for (int i = 0; i < l; i++) begin
            r |= ((d >> i) & 1) << (l - 1 - i);
        end
        return r;
    endfunction

    // state shared between driver and monitor
    int cur_sel = 0;
    bit cur_pol = 1'b1;
    bit cur_cpol = 1'b0;
    bit cur_cpha = 1'b0;
    int cur_len = 8;
    bit mon_en = 1'b0;
    int req_cnt = 0;
    bit stray = 1'b0;

    int cyc = 0;
    bit act_prev = 1'b0;
    bit sck_prev = 1'b0;
    int t_cs = 0;
    int t_first = 0;
    int t_last = 0;
    int edge_n = 0;
    bit first_chr = 1'b0;
    int ser = 0;

    // monitor: measures intervals and serial bits at the pins
    always @(negedge clk) begin
        bit act;
        if (rst_n && mon_en) begin
            act = cur_pol ? ~cs[cur_sel] : cs[cur_sel];
            for (int i = 0; i < NUM_CS; i++) begin
                if (i != cur_sel && cs[i] != cs_mode[i*32+20]) stray = 1'b1;
            end
            if (act && !act_prev) begin
                t_cs = cyc;
                edge_n = 0;
                first_chr = 1'b1;
                ser = 0;
                chk(sck == cur_cpol, "R3 clock level at select assert", int'(sck), int'(cur_cpol));
            end else if ((act || act_prev) && sck != sck_prev) begin
                edge_n++;
                if (edge_n == 1) begin
                    t_first = cyc;
                    if (first_chr) pop_chk(q_setup, "R6 setup interval", cyc - t_cs);
                    else           pop_chk(q_gap, "R8 gap interval", cyc - t_last);
                end
                if (first_chr && edge_n == 3) pop_chk(q_per, "R2 clock period", cyc - t_first);
                if (cur_cpha ? (edge_n % 2 == 0) : (edge_n % 2 == 1)) begin
                    ser = (ser << 1) | int'(mosi);
                end
                t_last = cyc;
                if (edge_n == 2 * cur_len) begin
                    pop_chk(q_ser, "R5 R4 serial order", ser);
                    edge_n = 0;
                    first_chr = 1'b0;
                    ser = 0;
                end
            end
            if (!act && act_prev) pop_chk(q_hold, "R7 hold interval", cyc - t_last);
            if (rx_valid) pop_chk(q_rx, "R10 received character", int'(rx_data));
            if (chr_req) req_cnt++;
            act_prev = act;
        end
        sck_prev = sck;
        cyc++;
    end

    task automatic run_xfer(input int sel, input logic [31:0] w, input int n,
                            input int d0, input int d1, input int d2, input bit intrude);
        int d [3];
        int l;
        int hp;
        int mask;
        bit idle_lvl;
        d[0] = d0; d[1] = d1; d[2] = d2;
        cs_mode[sel*32 +: 32] = w;
        cs_sel = 2'(sel);
        l = (w[19:16] < 4'd3) ? 4 : int'(w[19:16]) + 1;
        hp = 2 * (int'(w[27:24]) + 1) * (w[28] ? 16 : 1);
        mask = (1 << l) - 1;
        cur_sel = sel; cur_pol = w[20]; cur_cpol = w[31]; cur_cpha = w[30]; cur_len = l;
        idle_lvl = w[20];
        q_setup.push_back(2 * int'(w[15:12]) * hp + 1 + (w[30] ? 0 : hp));
        q_per.push_back(2 * hp);
        q_hold.push_back(2 * int'(w[11:8]) * hp + (w[30] ? hp : 0));
        for (int i = 0; i < n; i++) begin
            q_rx.push_back((~d[i]) & mask);
            q_ser.push_back(w[29] ? (d[i] & mask) : rev_bits(d[i] & mask, l));
            if (i > 0) q_gap.push_back(2 * int'(w[7:3]) * hp + hp + 1);
        end
        repeat (3) @(negedge clk);
        req_cnt = 0;
        stray = 1'b0;
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            while (!chr_req) @(negedge clk);
            chr_data = 16'(d[i]);
            chr_last = (i == n - 1);
            if (intrude && i == 1) begin
                start = 1'b1;
                cs_sel = 2'((sel + 1) % NUM_CS);
            end
            @(negedge clk);
            start = 1'b0;
            cs_sel = 2'(sel);
        end
        while (cs[sel] != idle_lvl) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        chk(req_cnt == n, "R10 one request per character", req_cnt, n);
        chk(!stray, "R9 R11 other select lines idle", int'(stray), 0);
        chk(sck == w[31], "R3 clock rest level after release", int'(sck), int'(w[31]));
        chk(cs[sel] == idle_lvl, "R9 select released level", int'(cs[sel]), int'(idle_lvl));
        chk((q_setup.size() + q_per.size() + q_gap.size() + q_hold.size()
             + q_rx.size() + q_ser.size()) == 0, "R6 all expected events seen",
            q_setup.size() + q_gap.size() + q_hold.size() + q_rx.size() + q_ser.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        chr_data = '0;
        chr_last = 1'b0;
        cs_sel = 2'd0;
        cs_mode = {32'h4110_1100, 32'h3003_0210, 32'hC21B_2000, 32'h2017_1108};
        repeat (4) @(negedge clk);
        chk(cs == 4'b1011, "R1 select idle levels in reset", int'(cs), 11);
        chk(sck == 1'b0, "R1 clock low in reset", int'(sck), 0);
        chk(!chr_req, "R1 no request in reset", int'(chr_req), 0);
        chk(!rx_valid, "R1 no valid in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // mode 0, msb first, 8 bits, one-period setup/hold/gap
        run_xfer(0, 32'h2017_1108, 2, 'hA5, 'h3C, 0, 1'b0);
        // idle-high clock, second-edge sampling, lsb first, 12 bits, start intrusion
        run_xfer(1, 32'hC21B_2000, 3, 'h5A3, 'hF0F, 'h123, 1'b1);
        // divide-by-16, 4 bits, active-high select, zero setup
        run_xfer(2, 32'h3003_0210, 1, 'h9, 0, 0, 1'b0);
        // length code 0 clamped to 4 bits, lsb first, zero gap
        run_xfer(3, 32'h4110_1100, 2, 'h1, 'hB, 0, 1'b0);
        // 16-bit characters, idle-high clock, first-edge sampling
        run_xfer(0, 32'hA01F_1108, 2, 'hC001, 'h1234, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule